// File: doc/BRIEF.md
# Quad Converter Serial Register Interface

This block is the digital front end of a four-channel, 12-bit voltage converter. A host sends 16-bit frames over a three-wire serial link made up of an active-low chip select, a serial clock and a data line. Each frame carries a 2-bit channel address and a 12-bit code. When a frame closes with the right length, the code is written into the input register of the addressed channel. The four converter cores are driven by four output-code registers. These only pick up new codes while an active-low load input is held low, so the host can stage all four channels and then update them together.

An active-low clear input overrides all four output codes at once and without waiting for a clock edge. A select pin decides whether the clear code is zero-scale (12'h000) or mid-scale (12'h800). Clear does not touch the input registers, so a load after clear is released brings the staged codes back. The serial pins and the load pin pass through synchronizers into the system clock domain. The converter cores, the reference and the output buffers are outside this block.

Top module: `qdac_serial_if`

## Requirements
- R1: After rst_ni is released, all four output codes read 12'h000, and all four input registers hold 12'h000.
- R2: While cs_ni is low, a bit is taken from sdi_i on each rising edge of sclk_i, most significant bit first. In the 16-bit frame, bits 15:14 are the channel address, bits 13:12 are ignored and bits 11:0 are the code.
- R3: On the rising edge of cs_ni, a valid frame writes its code into the input register picked by its address (0 = channel A at dac_code_o[0], up to 3 = channel D at dac_code_o[3]). The other three input registers do not change.
- R4: A frame with fewer or more than 16 rising sclk_i edges before cs_ni rises is thrown away, and no input register changes.
- R5: Rising edges of sclk_i while cs_ni is high are ignored and do not count toward the next frame.
- R6: Writing an input register leaves dac_code_o unchanged while load_ni stays high.
- R7: While load_ni is low and clear is not active, every output code takes the value of its input register.
- R8: While clr_ni is low, all four outputs show the clear code at once, with no clock edge needed. The clear code is 12'h000 when clr_sel_i = 0 and 12'h800 when clr_sel_i = 1.
- R9: Clear takes priority over load. Once clr_ni is released with load_ni high, the outputs keep the clear code.
- R10: Input registers keep their contents while clear is active, so a later load restores the codes that were staged before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi_i | input | 1 | Serial data in, MSB first |
| load_ni | input | 1 | Load strobe, active low; a level-sensitive copy into the outputs |
| clr_ni | input | 1 | Clear, active low; overrides the outputs asynchronously |
| clr_sel_i | input | 1 | Clear code select: 0 = zero-scale, 1 = mid-scale |
| dac_code_o | output | 4x12 | Output codes; index 0 is channel A |

## Verification
The assertions check four rules on every clock cycle. Clear forces the selected code onto all four outputs. The outputs hold steady when no load has been applied. A load copies the input registers. A valid frame writes exactly one input register, namely the addressed one. Only the bench scenarios can show how frames are built and filtered: that the ignored bits really have no effect, that short and long frames are dropped, and that stray serial clocks while chip select is high are not counted. The same goes for the asynchronous response of clear between clock edges, and for restoring the staged codes after a clear has been released.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned DEF_CHANNELS = 4;
  localparam int unsigned DEF_CODE_W   = 12;
  localparam int unsigned DEF_GAP_W    = 2;
  localparam int unsigned DEF_SYNC     = 2;

  typedef enum logic {
    CLR_TO_ZERO = 1'b0,
    CLR_TO_MID  = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= RESET_VAL;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RESET_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/qdac_serial_rx.sv
module qdac_serial_rx #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned GAP_W  = 2,
  parameter int unsigned CODE_W = 12,
  localparam int unsigned FRAME_W = ADDR_W + GAP_W + CODE_W,
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              sclk_s_i,
  input  logic              sdi_s_i,
  output logic              frame_valid_o,
  output logic [ADDR_W-1:0] frame_addr_o,
  output logic [CODE_W-1:0] frame_code_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic               sclk_q, cs_n_q;
  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sclk_rise, cs_rise;

  assign sclk_rise = sclk_s_i & ~sclk_q & ~cs_n_s_i;
  assign cs_rise   = cs_n_s_i & ~cs_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      cs_n_q <= cs_n_s_i;
    end
  end

  // count saturates one past a full frame so long frames stay rejected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (cs_n_s_i) begin
      cnt_q <= '0;
    end else if (sclk_rise) begin
      shift_q <= {shift_q[FRAME_W-2:0], sdi_s_i};
      if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_valid_o <= 1'b0;
      frame_addr_o  <= '0;
      frame_code_o  <= '0;
    end else begin
      frame_valid_o <= cs_rise && (cnt_q == CNT_FULL);
      if (cs_rise) begin
        frame_addr_o <= shift_q[FRAME_W-1 -: ADDR_W];
        frame_code_o <= shift_q[CODE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank #(
  parameter int unsigned CHANNELS = 4,
  parameter int unsigned CODE_W   = 12,
  localparam int unsigned ADDR_W  = $clog2(CHANNELS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             frame_valid_i,
  input  logic [ADDR_W-1:0]                frame_addr_i,
  input  logic [CODE_W-1:0]                frame_code_i,
  input  logic                             load_act_i,
  input  logic                             clr_act_i,
  input  logic [CODE_W-1:0]                clr_code_i,
  output logic [CHANNELS-1:0]              wr_en_o,
  output logic [CHANNELS-1:0][CODE_W-1:0]  in_code_o,
  output logic [CHANNELS-1:0][CODE_W-1:0]  out_code_o
);
  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    assign wr_en_o[g] = frame_valid_i && (frame_addr_i == ADDR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         in_code_o[g] <= '0;
      else if (wr_en_o[g]) in_code_o[g] <= frame_code_i;
    end

    // clear wins over load; input side untouched by clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         out_code_o[g] <= '0;
      else if (clr_act_i)  out_code_o[g] <= clr_code_i;
      else if (load_act_i) out_code_o[g] <= in_code_o[g];
    end
  end
endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if
  import qdac_pkg::*;
#(
  parameter int unsigned CHANNELS    = DEF_CHANNELS,
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter int unsigned GAP_W       = DEF_GAP_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cs_ni,
  input  logic                            sclk_i,
  input  logic                            sdi_i,
  input  logic                            load_ni,
  input  logic                            clr_ni,
  input  logic                            clr_sel_i,
  output logic [CHANNELS-1:0][CODE_W-1:0] dac_code_o
);
  localparam int unsigned ADDR_W = $clog2(CHANNELS);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [2:0]                      ser_s;
  logic                            load_s;
  logic                            load_act;
  logic                            clr_act;
  logic [CODE_W-1:0]               clr_code;
  logic                            frame_valid;
  logic [ADDR_W-1:0]               frame_addr;
  logic [CODE_W-1:0]               frame_code;
  logic [CHANNELS-1:0]             wr_en;
  logic [CHANNELS-1:0][CODE_W-1:0] in_code;
  logic [CHANNELS-1:0][CODE_W-1:0] out_q;
  clr_mode_e                       clr_mode;

  qdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b001)) i_ser_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdi_i, sclk_i, cs_ni}),
    .q_o   (ser_s)
  );

  qdac_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_load_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (load_ni),
    .q_o   (load_s)
  );

  assign load_act = ~load_s;
  assign clr_act  = ~clr_ni;
  assign clr_mode = clr_mode_e'(clr_sel_i);
  assign clr_code = (clr_mode == CLR_TO_MID) ? MID_CODE : '0;

  qdac_serial_rx #(.ADDR_W(ADDR_W), .GAP_W(GAP_W), .CODE_W(CODE_W)) i_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_n_s_i     (ser_s[0]),
    .sclk_s_i     (ser_s[1]),
    .sdi_s_i      (ser_s[2]),
    .frame_valid_o(frame_valid),
    .frame_addr_o (frame_addr),
    .frame_code_o (frame_code)
  );

  qdac_bank #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) i_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_valid_i(frame_valid),
    .frame_addr_i (frame_addr),
    .frame_code_i (frame_code),
    .load_act_i   (load_act),
    .clr_act_i    (clr_act),
    .clr_code_i   (clr_code),
    .wr_en_o      (wr_en),
    .in_code_o    (in_code),
    .out_code_o   (out_q)
  );

  // asynchronous override path, no clock edge required
  for (genvar g = 0; g < CHANNELS; g++) begin : g_out
    assign dac_code_o[g] = clr_act ? clr_code : out_q[g];
  end
endmodule

// File: rtl/qdac_serial_if_chk.sv
module qdac_serial_if_chk #(
  parameter int unsigned CHANNELS = 4,
  parameter int unsigned CODE_W   = 12,
  localparam int unsigned ADDR_W  = $clog2(CHANNELS)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            clr_ni,
  input logic                            clr_sel_i,
  input logic [CHANNELS-1:0][CODE_W-1:0] dac_code_o,
  input logic                            frame_valid,
  input logic [ADDR_W-1:0]               frame_addr,
  input logic [CODE_W-1:0]               frame_code,
  input logic [CHANNELS-1:0]             wr_en,
  input logic [CHANNELS-1:0][CODE_W-1:0] in_code,
  input logic                            load_act
);
  logic [CODE_W-1:0] exp_clr;
  assign exp_clr = clr_sel_i ? (CODE_W'(1) << (CODE_W - 1)) : '0;

  AST_CLEAR_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> dac_code_o == {CHANNELS{exp_clr}}); // R8

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && $past(clr_ni) && !$past(load_act)) |-> $stable(dac_code_o)); // R6

  AST_LOAD_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && $past(clr_ni) && $past(load_act)) |-> dac_code_o == $past(in_code)); // R7

  AST_ADDR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid |=> in_code[$past(frame_addr)] == $past(frame_code)); // R3

  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en)); // R3
endmodule

bind qdac_serial_if qdac_serial_if_chk #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_ni     (clr_ni),
  .clr_sel_i  (clr_sel_i),
  .dac_code_o (dac_code_o),
  .frame_valid(frame_valid),
  .frame_addr (frame_addr),
  .frame_code (frame_code),
  .wr_en      (wr_en),
  .in_code    (in_code),
  .load_act   (load_act)
);

// File: tb/test_qdac_serial_if.sv
module test_qdac_serial_if;
  localparam int CH = 4;
  localparam int W  = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic load_ni = 1'b1, clr_ni = 1'b1, clr_sel = 1'b0;
  logic [CH-1:0][W-1:0] dac_code;

  logic [W-1:0] exp_in  [CH];
  logic [W-1:0] exp_out [CH];
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qdac_serial_if i_qdac_serial_if (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk), .sdi_i(sdi),
    .load_ni(load_ni), .clr_ni(clr_ni), .clr_sel_i(clr_sel), .dac_code_o(dac_code)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_outs(input string req, input string what);
    for (int c = 0; c < CH; c++) begin
      checks++;
      if (dac_code[c] !== exp_out[c]) begin
        failures++;
        $display("FAIL %s %s ch%0d actual=%h expected=%h", req, what, c, dac_code[c], exp_out[c]);
      end
    end
  endtask

  task automatic send_bits(input int nbits, input logic [15:0] word);
    @(negedge clk);
    cs_ni = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      sdi  = (i < 16) ? word[15-i] : 1'b1;
      sclk = 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
    end
    sclk = 1'b0;
    wait_clk(4);
    cs_ni = 1'b1;
    wait_clk(8);
  endtask

  function automatic logic [15:0] mk(input int ch, input logic [W-1:0] code, input logic [1:0] gap);
    return {2'(ch), gap, code};
  endfunction

  task automatic pulse_load();
    load_ni = 1'b0;
    wait_clk(6);
    load_ni = 1'b1;
    wait_clk(6);
  endtask

  task automatic load_model();
    for (int c = 0; c < CH; c++) exp_out[c] = exp_in[c];
  endtask

  initial begin
    for (int c = 0; c < CH; c++) begin exp_in[c] = '0; exp_out[c] = '0; end
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(4);
    check_outs("R1", "reset outputs");
    pulse_load();
    check_outs("R1", "reset input regs via load");

    // R2 R3 R6 R7 sweep over channels and codes, ignored bits varied
    for (int k = 0; k < 5; k++) begin
      for (int c = 0; c < CH; c++) begin
        logic [W-1:0] code;
        code = W'((c * 12'h3A5 + k * 12'h517) ^ (k == 4 ? 12'hFFF : 12'h000));
        send_bits(16, mk(c, code, 2'(k + c)));
        exp_in[c] = code;
        check_outs("R6", "outputs held before load");
      end
      pulse_load();
      load_model();
      check_outs("R7", "outputs after load");
    end

    // R3 single channel write leaves others
    send_bits(16, mk(2, 12'hABC, 2'b11));
    exp_in[2] = 12'hABC;
    pulse_load();
    load_model();
    check_outs("R3", "only addressed channel changes");

    // R4 short and long frames dropped
    send_bits(15, mk(1, 12'h123, 2'b00));
    send_bits(17, mk(3, 12'h456, 2'b00));
    send_bits(1, mk(0, 12'h789, 2'b00));
    pulse_load();
    check_outs("R4", "wrong-length frames discarded");

    // R5 stray clocks with cs high, then a good frame
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4);
    end
    send_bits(16, mk(0, 12'h5A5, 2'b01));
    exp_in[0] = 12'h5A5;
    pulse_load();
    load_model();
    check_outs("R5", "clocks with cs high ignored");

    // R8 asynchronous clear, both codes
    for (int s = 0; s < 2; s++) begin
      @(posedge clk); #3;
      clr_sel = 1'(s);
      clr_ni = 1'b0;
      #2;
      for (int c = 0; c < CH; c++) exp_out[c] = s ? 12'h800 : 12'h000;
      check_outs("R8", "clear before any clock edge");
      wait_clk(4);
      // R9 clear over load
      load_ni = 1'b0;
      wait_clk(6);
      check_outs("R9", "clear wins over load");
      load_ni = 1'b1;
      wait_clk(6);
      send_bits(16, mk(3, 12'h0F0 + W'(s), 2'b10));
      exp_in[3] = 12'h0F0 + W'(s);
      clr_ni = 1'b1;
      wait_clk(6);
      check_outs("R9", "clear code kept after release");
      pulse_load();
      load_model();
      check_outs("R10", "staged codes restored by load");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule